// File: doc/BRIEF.md
# Vector Expand/Compress Sequencer

This block walks a vector register one element position at a time and moves only the elements whose mask bit is set. In expand-load mode it takes consecutive elements from storage and writes each one into the next vector position whose mask bit is one. Positions with a zero mask bit are never written. In compress-store mode it reads the mask-selected vector elements and writes them to consecutive storage locations. The mask always decides which elements move. No separate mask-mode setting exists, and none would change the result.

A run starts with a one-cycle `start` pulse. On that pulse the block captures the element count C, the starting index X, the mask and the operation select. Positions X through C-1 are scanned in ascending order. For each selected position the block raises a single storage request and holds it until `mem_ack` arrives. On the acknowledged cycle it pulses `mem_adv`, and an external address register uses that pulse to step one element. A run with a zero net count (C <= X), or with no selected mask bit in the window, makes no request and never pulses `mem_adv`. In both cases it finishes with index zero. An interrupt request is taken between elements. The run then ends with `final_idx` holding the next unprocessed position Y, so a later run can resume from Y.

The states are IDLE, SCAN, XFER and FINISH, with these transitions:
- IDLE goes to SCAN on `start` when the window has a set bit.
- IDLE goes to FINISH on `start` when the window is empty.
- SCAN goes to FINISH when the index reaches C (completion).
- SCAN goes to FINISH on `intr_req` (interrupt).
- SCAN goes to XFER when the current mask bit is one.
- SCAN stays in SCAN and steps the index when the current mask bit is zero.
- XFER goes back to SCAN and steps the index on `mem_ack`, and stays in XFER without it.
- FINISH always goes to IDLE.

Top module: `vxc_seq`

## Requirements
- R1: When `start` is accepted with `vec_count <= start_idx`, the next cycle is FINISH. In that cycle `done`=1, `final_idx`=0 and `interrupted`=0, and no storage request is made during the run.
- R2: Storage requests go only to positions i with start_idx <= i < vec_count and mask[i]=1. They are issued in strictly ascending position order, and `vr_idx` gives the position of each request.
- R3: When the net count is nonzero but every mask bit in positions start_idx to vec_count-1 is zero, no storage request and no `mem_adv` pulse occur, and the run finishes with `final_idx`=0. Mask bits outside that window have no effect.
- R4: Expand load (`op_compress`=0): `mem_we`=0 while a request is raised. `vr_we` pulses only in the cycle where the request is acknowledged, at the selected position.
- R5: Compress store (`op_compress`=1): `mem_we`=1 and `vr_re`=1 while a request is raised. `vr_we` stays 0.
- R6: At most one request is outstanding. Once raised, `mem_req` and `vr_idx` hold steady until `mem_ack`. `mem_adv` pulses exactly once per acknowledged transfer, and the index then steps by one.
- R7: When `intr_req` is high in a SCAN cycle before completion, the run ends with `interrupted`=1. `final_idx` then equals Y, the next unprocessed position, with start_idx <= Y < vec_count, and exactly the selected positions in [start_idx, Y) have been transferred.
- R8: On completion without interrupt, `interrupted`=0 and `final_idx`=0, and every selected position in the window has been transferred exactly once.
- R9: `busy` is high from the accepted start until the FINISH cycle inclusive. `done` pulses for exactly one cycle. A `start`, or a change of any run input, while busy has no effect on the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| op_compress | input | 1 | 0 = expand load, 1 = compress store |
| vec_count | input | CNT_W | Element count C |
| start_idx | input | CNT_W | Starting index X |
| mask | input | VLEN | Element select mask |
| intr_req | input | 1 | Interrupt request, taken between elements |
| mem_ack | input | 1 | Storage acknowledge for the current request |
| mem_req | output | 1 | Storage request |
| mem_we | output | 1 | Storage write (compress) when requesting |
| mem_adv | output | 1 | Address-advance strobe, one per transfer |
| vr_idx | output | IDX_W | Vector element position being accessed |
| vr_we | output | 1 | Vector element write (expand) |
| vr_re | output | 1 | Vector element read (compress) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| interrupted | output | 1 | Run ended by interrupt (valid with done) |
| final_idx | output | CNT_W | Resume index Y, or 0 on completion (valid with done) |

## Verification
The embedded assertions check the cycle-level rules every cycle:
- an unacknowledged request holds with a steady index;
- each acknowledged transfer steps the index by exactly one;
- no request goes past the captured count;
- a zero-net-count start finishes at once with index zero;
- a completed run reports index zero;
- an interrupted run reports a resume index below the count;
- `done` lasts one cycle and is followed by idle.

Only the bench's scenarios can show the rest. These are:
- that the set of positions moved is exactly the selected bits of the window, in order;
- that an empty window makes no access;
- that the resume index agrees with the transfers that actually happened;
- that a mid-run restart attempt leaves the result unchanged.

// File: rtl/vxc_pkg.sv
package vxc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_XFER   = 2'd2,
        ST_FINISH = 2'd3
    } vxc_state_e;

endpackage

// File: rtl/vxc_range_mask.sv
// Keeps the mask bits whose position lies in [lo, hi) and flags whether any survive.
module vxc_range_mask #(
    parameter int VLEN  = 16,
    parameter int CNT_W = 5
) (
    input  logic [VLEN-1:0]  mask,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    output logic [VLEN-1:0]  win,
    output logic             any
);

    for (genvar i = 0; i < VLEN; i++) begin : g_bit
        localparam logic [CNT_W-1:0] POS = CNT_W'(i);
        assign win[i] = mask[i] && (POS >= lo) && (POS < hi);
    end

    assign any = |win;

endmodule

// File: rtl/vxc_elem_ctr.sv
// Element index register: clear has priority over load, load over increment.
module vxc_elem_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + W'(1);
    end

endmodule

// File: rtl/vxc_seq.sv
module vxc_seq
    import vxc_pkg::*;
#(
    parameter  int VLEN  = 16,
    localparam int CNT_W = $clog2(VLEN) + 1,
    localparam int IDX_W = $clog2(VLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_compress,
    input  logic [CNT_W-1:0] vec_count,
    input  logic [CNT_W-1:0] start_idx,
    input  logic [VLEN-1:0]  mask,
    input  logic             intr_req,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_adv,
    output logic [IDX_W-1:0] vr_idx,
    output logic             vr_we,
    output logic             vr_re,
    output logic             busy,
    output logic             done,
    output logic             interrupted,
    output logic [CNT_W-1:0] final_idx
);

    vxc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [VLEN-1:0]  win_q, win_d;
    logic             op_q;
    logic             intr_q;
    logic             win_any;
    logic             ctr_clr, ctr_load, ctr_inc;
    logic             at_end;
    logic             sel_bit;

    vxc_range_mask #(.VLEN(VLEN), .CNT_W(CNT_W)) u_window (
        .mask (mask),
        .lo   (start_idx),
        .hi   (vec_count),
        .win  (win_d),
        .any  (win_any)
    );

    vxc_elem_ctr #(.W(CNT_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .load     (ctr_load),
        .load_val (start_idx),
        .inc      (ctr_inc),
        .q        (idx_q)
    );

    assign at_end  = (idx_q == cnt_q);
    assign sel_bit = win_q[idx_q[IDX_W-1:0]];

    // Next-state and index control
    always_comb begin
        state_d  = state_q;
        ctr_clr  = 1'b0;
        ctr_load = 1'b0;
        ctr_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (win_any) begin
                        state_d  = ST_SCAN;
                        ctr_load = 1'b1;
                    end else begin
                        state_d = ST_FINISH;   // zero net count or empty window
                        ctr_clr = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (at_end) begin
                    state_d = ST_FINISH;
                    ctr_clr = 1'b1;
                end else if (intr_req) begin
                    state_d = ST_FINISH;       // index keeps resume point
                end else if (sel_bit) begin
                    state_d = ST_XFER;
                end else begin
                    ctr_inc = 1'b1;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    state_d = ST_SCAN;
                    ctr_inc = 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            win_q   <= '0;
            op_q    <= 1'b0;
            intr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                cnt_q  <= vec_count;
                win_q  <= win_d;
                op_q   <= op_compress;
                intr_q <= 1'b0;
            end else if (state_q == ST_SCAN && !at_end && intr_req) begin
                intr_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req     = (state_q == ST_XFER);
        mem_we      = mem_req && op_q;
        mem_adv     = mem_req && mem_ack;
        vr_we       = mem_adv && !op_q;
        vr_re       = mem_req && op_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FINISH);
        interrupted = done && intr_q;
        final_idx   = done ? idx_q : '0;
    end
    assign vr_idx = idx_q[IDX_W-1:0];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(vr_idx)); // R6
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_adv |=> idx_q == $past(idx_q) + CNT_W'(1)); // R6
    AST_REQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> idx_q < cnt_q); // R2
    AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (vec_count <= start_idx) |=> done && final_idx == '0 && !interrupted); // R1
    AST_COMPLETE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !interrupted |-> final_idx == '0); // R8
    AST_INTR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        done && interrupted |-> final_idx < cnt_q); // R7
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R9

endmodule

// File: tb/test_vxc_seq.sv
module test_vxc_seq;
    localparam int VLEN  = 16;
    localparam int CNT_W = $clog2(VLEN) + 1;
    localparam int IDX_W = $clog2(VLEN);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, start, op_compress, intr_req, mem_ack;
    logic [CNT_W-1:0] vec_count, start_idx, final_idx;
    logic [VLEN-1:0]  mask;
    logic             mem_req, mem_we, mem_adv, vr_we, vr_re, busy, done, interrupted;
    logic [IDX_W-1:0] vr_idx;

    vxc_seq #(.VLEN(VLEN)) i_vxc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_compress(op_compress),
        .vec_count(vec_count), .start_idx(start_idx), .mask(mask),
        .intr_req(intr_req), .mem_ack(mem_ack), .mem_req(mem_req),
        .mem_we(mem_we), .mem_adv(mem_adv), .vr_idx(vr_idx), .vr_we(vr_we),
        .vr_re(vr_re), .busy(busy), .done(done), .interrupted(interrupted),
        .final_idx(final_idx)
    );

    int checks = 0;
    int errors = 0;
    int got_n;
    int got_idx [VLEN];
    int bad_strobe;
    int held_err;
    bit seen_done;
    int fin_idx;
    bit fin_intr;
    bit cur_op;
    bit ack_rand = 1'b0;
    bit prev_wait = 1'b0;
    int prev_idx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Acknowledge driver and observer: drive ack, let it settle, then record
    always @(negedge clk) begin
        mem_ack = ack_rand ? 1'($urandom_range(0, 1)) : 1'b1;
        #1;
        if (prev_wait && (!mem_req || int'(vr_idx) != prev_idx)) held_err++;
        prev_wait = mem_req && !mem_ack;
        prev_idx  = int'(vr_idx);
        if (mem_req && mem_ack) begin
            if (got_n < VLEN) got_idx[got_n] = int'(vr_idx);
            got_n++;
        end
        if (mem_req && (mem_we != cur_op)) bad_strobe++;
        if (mem_req && (vr_re != cur_op)) bad_strobe++;
        if (vr_we != (mem_req && mem_ack && !cur_op)) bad_strobe++;
        if (mem_adv != (mem_req && mem_ack)) bad_strobe++;
        if (done) begin
            seen_done = 1'b1;
            fin_idx   = int'(final_idx);
            fin_intr  = interrupted;
        end
    end

    task automatic run(input bit op, input int c, input int x, input logic [VLEN-1:0] m,
                       input int icyc, input bit restart);
        int cyc;
        int hi;
        int n_exp;
        int exp_list [VLEN];
        @(negedge clk);
        cur_op = op; got_n = 0; bad_strobe = 0; held_err = 0; seen_done = 1'b0;
        vec_count = CNT_W'(c); start_idx = CNT_W'(x); mask = m; op_compress = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!seen_done && cyc < 400) begin
            if (icyc >= 0 && cyc == icyc) intr_req = 1'b1;
            if (restart && cyc == 2) begin
                start = 1'b1; mask = ~m; op_compress = ~op; vec_count = CNT_W'(VLEN); start_idx = '0;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; intr_req = 1'b0;
        vec_count = CNT_W'(c); start_idx = CNT_W'(x); mask = m; op_compress = op;
        chk(seen_done, "R9 run ends", int'(seen_done), 1);
        @(negedge clk);
        #2;
        chk(!busy && !done, "R9 idle after done", int'(busy), 0);
        hi = fin_intr ? fin_idx : c;
        n_exp = 0;
        for (int i = x; i < hi && i < VLEN; i++)
            if (m[i]) begin exp_list[n_exp] = i; n_exp++; end
        if (c <= x) begin
            chk(got_n == 0 && fin_idx == 0 && !fin_intr, "R1 net zero", got_n, 0);
        end else if (n_exp == 0 && !fin_intr) begin
            chk(got_n == 0 && fin_idx == 0, "R3 empty window", got_n, 0);
        end
        if (fin_intr)
            chk(fin_idx >= x && fin_idx < c, "R7 resume index", fin_idx, x);
        else
            chk(fin_idx == 0, "R8 completion index", fin_idx, 0);
        if (icyc < 0) chk(!fin_intr, "R8 no interrupt", int'(fin_intr), 0);
        chk(got_n == n_exp, "R2 transfer count", got_n, n_exp);
        for (int k = 0; k < n_exp && k < got_n; k++)
            chk(got_idx[k] == exp_list[k], "R2 transfer order", got_idx[k], exp_list[k]);
        chk(bad_strobe == 0, op ? "R5 compress strobes" : "R4 expand strobes", bad_strobe, 0);
        chk(held_err == 0, "R6 request hold", held_err, 0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int x;
        int ic;
        logic [VLEN-1:0] m;
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; op_compress = 1'b0; intr_req = 1'b0;
        vec_count = '0; start_idx = '0; mask = '0;
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !mem_req && !done, "R9 reset state", int'(busy), 0);
        rst_n = 1'b1;

        run(1'b0, 3, 5, 16'hFFFF, -1, 1'b0);            // R1 C < X
        run(1'b1, 0, 0, 16'hFFFF, -1, 1'b0);            // R1 C = 0
        run(1'b0, 8, 2, 16'hFC03, -1, 1'b0);            // R3 bits only outside window
        run(1'b1, VLEN, 0, 16'hFFFF, -1, 1'b0);         // R5 full compress
        run(1'b0, 12, 1, 16'hAAAA, -1, 1'b0);           // R4 alternating expand
        run(1'b0, 10, 3, 16'h0FF8, 0, 1'b0);            // R7 immediate interrupt
        chk(fin_intr && fin_idx == 3 && got_n == 0, "R7 interrupt at start index", fin_idx, 3);
        run(1'b1, 9, 1, 16'h0156, -1, 1'b1);            // R9 restart ignored while busy
        ack_rand = 1'b1;
        run(1'b0, VLEN, 0, 16'h8001, -1, 1'b0);         // R6 random acknowledge
        for (int t = 0; t < 40; t++) begin
            c  = $urandom_range(0, VLEN);
            x  = $urandom_range(0, VLEN);
            m  = VLEN'($urandom);
            ic = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 20) : -1;
            run(1'($urandom_range(0, 1)), c, x, m, ic, 1'($urandom_range(0, 3) == 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule